// File: doc/BRIEF.md
# Transmit Dominant Timeout Guard

This block sits between the synchronised transmit input of a single-wire bus transceiver and the low-side output stage. It stops a stuck or shorted transmit line from holding the bus dominant forever. It has four named states:

- `GS_IDLE`: the driver is off.
- `GS_QUALIFY`: transmit high is being timed.
- `GS_ARMED`: the driver follows the transmit input and low time is being timed.
- `GS_TRIPPED`: an overlong dominant period has forced the driver recessive.

The transitions are:

- `GS_IDLE` to `GS_QUALIFY` when normal mode is active and transmit is high.
- `GS_QUALIFY` to `GS_ARMED` after `REARM_TICKS` consecutive microsecond ticks of transmit high.
- `GS_QUALIFY` to `GS_IDLE` when transmit drops low or normal mode ends.
- `GS_ARMED` to `GS_TRIPPED` after `DOM_TICKS` consecutive ticks of transmit low.
- `GS_TRIPPED` to `GS_QUALIFY` when transmit returns high.
- `GS_ARMED` or `GS_TRIPPED` to `GS_IDLE` when normal mode ends.

Both timings share one counter that advances on an external microsecond tick. A separate selector turns an enable-falling request into a sleep or a silent request. It decides from the raw transmit level, not from the timeout state, so a node with a shorted transmit line can still reach sleep.

Top module: `txd_timeout_guard`

## Requirements
- R1: In `GS_ARMED` with `txd_in` held low for `DOM_TICKS` consecutive `us_tick` pulses, `drv_dominant` and `drv_armed` fall at the clock edge that samples the last pulse. Fewer pulses, or a single high cycle in between, keep the driver armed.
- R2: After a trip, the driver re-arms only after `txd_in` has been high for `REARM_TICKS` consecutive ticks, counted from the cycle after it rose. Any low cycle restarts the qualification.
- R3: On entry into normal mode, `drv_armed` stays 0 until the same `REARM_TICKS` high qualification has completed. A low `txd_in` at entry never drives the bus.
- R4: `txd_in` = 0 requests dominant and `txd_in` = 1 requests recessive. `drv_dominant` is 1 only when `drv_armed` is 1 and `txd_in` is 0.
- R5: With `mode_normal` = 0, `drv_armed` and `drv_dominant` are 0 and ticks have no effect. Dropping `mode_normal` returns the guard to `GS_IDLE`.
- R6: A `lp_req` pulse in normal mode gives a one-cycle `sleep_req` in the next cycle if `txd_in` was 0, or `silent_req` if it was 1. This holds whether or not a timeout is in force.
- R7: `timeout_flag` sets on a trip, stays set when normal mode is left, and clears when the driver re-arms.
- R8: A `lp_req` pulse with `mode_normal` = 0 produces neither request.
- R9: During and after reset, all outputs are 0 and the guard is in `GS_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| mode_normal | input | 1 | 1 while the transceiver is in normal mode |
| txd_in | input | 1 | Synchronised transmit input, 0 = dominant request |
| lp_req | input | 1 | One-cycle pulse: enable fell, choose a low-power mode |
| drv_dominant | output | 1 | 1 pulls the bus dominant |
| drv_armed | output | 1 | Driver enabled to follow `txd_in` |
| timeout_flag | output | 1 | Sticky indication of a dominant timeout |
| sleep_req | output | 1 | One-cycle request to enter sleep |
| silent_req | output | 1 | One-cycle request to enter silent |

## Verification
The bench builds the guard with `DOM_TICKS` = 20 and `REARM_TICKS` = 5 and drives `us_tick` itself. This makes every boundary reachable in a few hundred cycles: one tick short of the timeout, the exact tripping tick, and a qualification broken one tick before completion. With small limits, a high blip in the middle of a long dominant run visibly restarts the count. Sleep selection after a trip with transmit stuck low is exercised at the same scale.

// File: rtl/txg_pkg.sv
package txg_pkg;
    typedef enum logic [1:0] {
        GS_IDLE     = 2'd0,
        GS_QUALIFY  = 2'd1,
        GS_ARMED    = 2'd2,
        GS_TRIPPED  = 2'd3
    } guard_state_t;
endpackage

// File: rtl/txg_tick_counter.sv
module txg_tick_counter #(
    parameter int W   = 8,
    parameter int MAX = 255
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = W'(MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (inc && cnt != TOP)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/txg_lowpower_select.sv
module txg_lowpower_select (
    input  logic clk,
    input  logic rst_n,
    input  logic lp_req,
    input  logic mode_normal,
    input  logic txd_in,
    output logic sleep_req,
    output logic silent_req
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sleep_req  <= 1'b0;
            silent_req <= 1'b0;
        end else begin
            sleep_req  <= lp_req && mode_normal && !txd_in;
            silent_req <= lp_req && mode_normal && txd_in;
        end
    end

    // R6
    sleep_uses_raw_txd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |-> !$past(txd_in));

    // R6
    lp_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sleep_req && silent_req));

    // R8
    lp_only_in_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_req || silent_req) |-> $past(mode_normal));
endmodule

// File: rtl/txd_timeout_guard.sv
module txd_timeout_guard
    import txg_pkg::*;
#(
    parameter int DOM_TICKS   = 55000,
    parameter int REARM_TICKS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic us_tick,
    input  logic mode_normal,
    input  logic txd_in,
    input  logic lp_req,
    output logic drv_dominant,
    output logic drv_armed,
    output logic timeout_flag,
    output logic sleep_req,
    output logic silent_req
);
    localparam int LONGEST = (DOM_TICKS > REARM_TICKS) ? DOM_TICKS : REARM_TICKS;
    localparam int CW      = $clog2(LONGEST + 1);
    localparam logic [CW-1:0] DOM_LAST   = CW'(DOM_TICKS - 1);
    localparam logic [CW-1:0] REARM_LAST = CW'(REARM_TICKS - 1);

    guard_state_t      state, state_nx;
    logic              cnt_clr;
    logic [CW-1:0]     cnt;

    txg_tick_counter #(.W(CW), .MAX(LONGEST)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (us_tick),
        .cnt   (cnt)
    );

    txg_lowpower_select u_lp (
        .clk         (clk),
        .rst_n       (rst_n),
        .lp_req      (lp_req),
        .mode_normal (mode_normal),
        .txd_in      (txd_in),
        .sleep_req   (sleep_req),
        .silent_req  (silent_req)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            GS_IDLE:
                if (mode_normal && txd_in) state_nx = GS_QUALIFY;
            GS_QUALIFY:
                if (!mode_normal || !txd_in)        state_nx = GS_IDLE;
                else if (us_tick && cnt == REARM_LAST) state_nx = GS_ARMED;
            GS_ARMED:
                if (!mode_normal)                              state_nx = GS_IDLE;
                else if (!txd_in && us_tick && cnt == DOM_LAST) state_nx = GS_TRIPPED;
            GS_TRIPPED:
                if (!mode_normal)  state_nx = GS_IDLE;
                else if (txd_in)   state_nx = GS_QUALIFY;
            default:
                state_nx = GS_IDLE;
        endcase
        cnt_clr = (state_nx != state) || (state == GS_IDLE) ||
                  (state == GS_TRIPPED) || (state == GS_ARMED && txd_in);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= GS_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            timeout_flag <= 1'b0;
        else if (state_nx == GS_TRIPPED && state != GS_TRIPPED)
            timeout_flag <= 1'b1;
        else if (state_nx == GS_ARMED && state != GS_ARMED)
            timeout_flag <= 1'b0;
    end

    always_comb begin
        drv_armed    = (state == GS_ARMED) && mode_normal;
        drv_dominant = drv_armed && !txd_in;
    end

    // R4
    recessive_on_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txd_in |-> !drv_dominant);

    // R1
    trip_after_dominant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_flag) |-> $past(drv_dominant));

    // R2
    arm_needs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == GS_ARMED && $past(state) != GS_ARMED) |-> $past(txd_in));

    // R5
    leave_normal_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mode_normal) |=> (state == GS_IDLE));

    // R7
    flag_clear_on_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(timeout_flag) |-> (state == GS_ARMED));
endmodule

// File: tb/sim_txd_timeout_guard.sv
module sim_txd_timeout_guard;
    localparam int DOM   = 20;
    localparam int REARM = 5;
    localparam int NV    = 18;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic us_tick = 1'b0, mode_normal = 1'b0, txd_in = 1'b1, lp_req = 1'b0;
    logic drv_dominant, drv_armed, timeout_flag, sleep_req, silent_req;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    txd_timeout_guard #(.DOM_TICKS(DOM), .REARM_TICKS(REARM)) u0 (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .mode_normal(mode_normal),
        .txd_in(txd_in), .lp_req(lp_req), .drv_dominant(drv_dominant),
        .drv_armed(drv_armed), .timeout_flag(timeout_flag),
        .sleep_req(sleep_req), .silent_req(silent_req)
    );

    // fields: [22] normal [21] txd [20:13] ticks [12:5] req [2] armed [1] dominant [0] flag
    function automatic logic [22:0] mk(input logic n, input logic t, input int k,
                                       input int r, input logic a, input logic d, input logic f);
        return {n, t, 8'(k), 8'(r), 2'b00, a, d, f};
    endfunction

    localparam logic [22:0] VEC [NV] = '{
        mk(1, 1, 4,  3, 0, 0, 0),   // R3 qualification not complete
        mk(1, 1, 1,  3, 1, 0, 0),   // R3 armed on fifth tick
        mk(1, 0, 0,  4, 1, 1, 0),   // R4 low drives dominant
        mk(1, 0, 19, 1, 1, 1, 0),   // R1 one tick short
        mk(1, 0, 1,  1, 0, 0, 1),   // R1 trip, R7 flag set
        mk(1, 0, 30, 1, 0, 0, 1),   // R1 stays tripped while low
        mk(1, 1, 4,  2, 0, 0, 1),   // R2 qualifying
        mk(1, 0, 3,  2, 0, 0, 1),   // R2 low breaks qualification
        mk(1, 1, 4,  2, 0, 0, 1),   // R2 count restarted
        mk(1, 1, 1,  7, 1, 0, 0),   // R7 re-arm clears flag
        mk(1, 0, 15, 1, 1, 1, 0),   // R1 partial run
        mk(1, 1, 0,  4, 1, 0, 0),   // R4 high blip recessive
        mk(1, 0, 15, 1, 1, 1, 0),   // R1 count restarted by blip
        mk(0, 0, 0,  5, 0, 0, 0),   // R5 leaving normal disarms
        mk(0, 1, 10, 5, 0, 0, 0),   // R5 ticks outside normal
        mk(1, 0, 10, 3, 0, 0, 0),   // R3 entry with txd low
        mk(1, 1, 4,  3, 0, 0, 0),   // R3 qualifying after entry
        mk(1, 1, 1,  3, 1, 0, 0)    // R3 armed
    };

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic pulse_ticks(input int k);
        for (int i = 0; i < k; i++) begin
            us_tick = 1'b1;
            @(negedge clk);
            us_tick = 1'b0;
        end
    endtask

    task automatic pulse_lp();
        lp_req = 1'b1;
        @(negedge clk);
        lp_req = 1'b0;
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 armed", drv_armed, 1'b0);
        check("R9 dominant", drv_dominant, 1'b0);
        check("R9 flag", timeout_flag, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            mode_normal = VEC[v][22];
            txd_in      = VEC[v][21];
            @(negedge clk);
            pulse_ticks(int'(VEC[v][20:13]));
            check($sformatf("R%0d step %0d armed", VEC[v][12:5], v), drv_armed, VEC[v][2]);
            check($sformatf("R%0d step %0d dominant", VEC[v][12:5], v), drv_dominant, VEC[v][1]);
            check($sformatf("R%0d step %0d flag", VEC[v][12:5], v), timeout_flag, VEC[v][0]);
        end

        // R6: trip with txd stuck low, then sleep request still chosen
        txd_in = 1'b0;
        @(negedge clk);
        pulse_ticks(DOM);
        check("R1 trip before sleep", timeout_flag, 1'b1);
        pulse_lp();
        check("R6 sleep after timeout", sleep_req, 1'b1);
        check("R6 no silent", silent_req, 1'b0);
        @(negedge clk);
        check("R6 sleep one cycle", sleep_req, 1'b0);

        // R7 flag survives leaving normal; R8 requests ignored outside normal
        mode_normal = 1'b0;
        @(negedge clk);
        check("R7 flag sticky", timeout_flag, 1'b1);
        check("R5 disarmed", drv_armed, 1'b0);
        pulse_lp();
        check("R8 no sleep", sleep_req, 1'b0);
        check("R8 no silent", silent_req, 1'b0);

        // R6 silent when txd high
        mode_normal = 1'b1;
        txd_in = 1'b1;
        @(negedge clk);
        pulse_lp();
        check("R6 silent", silent_req, 1'b1);
        check("R6 no sleep", sleep_req, 1'b0);

        // R9 reset mid-operation
        pulse_ticks(REARM);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 reset armed", drv_armed, 1'b0);
        check("R9 reset flag", timeout_flag, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule